// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command bus from reset until the memory is ready. It drives only NOP while a fixed power-up pause runs, then issues one precharge of all banks, eight auto-refresh commands and a mode register load. After a fixed settling gap it raises `init_done`. From that cycle on, the command bus belongs to an external read/write path, and the block only pulses `ref_req` at a programmable interval so that path can schedule auto-refresh.

Before the first command, the block checks the configuration inputs. The geometry is given as offsets from a minimum width: column bits minus 8, row bits minus 11, and bank bits minus 1. The refresh interval is given in clock cycles. A zero interval, or a geometry that does not fit the address and bank buses, stops the sequence. In that case an error flag is raised in place of any command. All configuration inputs must be held steady while the block is out of reset.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset is released, `sd_cmd` is NOP (4'b0111, encoded {cs_n, ras_n, cas_n, we_n}) on every cycle before cycle PAUSE_CYC = (CLK_HZ/1e6)*PAUSE_US. The first command appears in cycle PAUSE_CYC, counting the first rising edge with reset low as cycle 1. During reset, `sd_cmd` is NOP and `init_done`, `ref_req` and `cfg_err` are low.
- R2: The first command is precharge-all: `sd_cmd` = 4'b0010, `sd_addr` bit 10 set and all other address bits zero, `sd_ba` zero.
- R3: Exactly eight auto-refresh commands (`sd_cmd` = 4'b0001, address and bank zero) follow. Precharge-all and the first refresh are separated by `t_rp` NOP cycles, and each refresh is followed by `t_rc` NOP cycles before the next command.
- R4: After the eighth refresh gap, one mode register load (`sd_cmd` = 4'b0000) is issued. `sd_addr` carries `cas_lat` in bits 6:4, zeros in bits 3:0 (burst length 1, sequential) and zeros elsewhere. `sd_ba` is zero.
- R5: The mode load is followed by exactly 3 NOP cycles. `init_done` rises in the next cycle (the mode load cycle plus 4) and stays high until reset. From then on `sd_cmd` stays NOP.
- R6: `ref_req` is a one-cycle pulse. The first pulse comes `refresh_interval` cycles after `init_done` rises, and each later pulse comes `refresh_interval` cycles after the previous one. The interval is read again at every pulse.
- R7: If `refresh_interval` is zero, `cfg_err` rises in cycle PAUSE_CYC in place of the precharge-all. `init_done` stays low and no command other than NOP is driven.
- R8: A geometry whose row bits (`row_code`+11) exceed ADDR_W, whose column bits (`col_code`+8) exceed 10, or whose bank bits (`bank_code`+1) exceed BA_W is handled in the same way as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cas_lat | input | 3 | CAS latency written into the mode word |
| col_code | input | 2 | Column address bits minus 8 |
| row_code | input | 2 | Row address bits minus 11 |
| bank_code | input | 1 | Bank address bits minus 1 |
| t_rp | input | TW | NOP cycles after precharge-all |
| t_rc | input | TW | NOP cycles after each auto-refresh |
| refresh_interval | input | IW | Cycles between refresh requests |
| sd_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| sd_addr | output | ADDR_W | SDRAM address bus |
| sd_ba | output | BA_W | SDRAM bank address |
| init_done | output | 1 | Bus handed to the read/write path |
| ref_req | output | 1 | One-cycle refresh request pulse |
| cfg_err | output | 1 | Configuration rejected; sequence halted |

## Verification
Two valid configurations are run. The first has long gaps and a large interval. The second has a zero precharge gap, a one-cycle refresh gap and a different CAS latency, and it changes the refresh interval after the first request. Together they separate the two gap inputs from each other and from the fixed settling gap, show that the mode word tracks `cas_lat`, and confirm that the interval is re-read at each reload rather than latched once. Three faulty configurations follow: a zero interval, rows too wide and columns too wide. They show that each check blocks the sequence independently and leaves the bus idle. The second run starts by resetting a block that is already in normal mode, which exercises the return to the reset state.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  // Command code: {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_GAP_RP,
    ST_GAP_RC,
    ST_GAP_MRD,
    ST_NORMAL,
    ST_FAULT
  } seq_state_e;

  localparam int REFRESH_BURST = 8;
  localparam int MRD_CYCLES    = 3;
  localparam int ALL_BANK_BIT  = 10;
  localparam int CAS_LSB       = 4;
  localparam int COL_BITS_MAX  = 10;
endpackage

// File: rtl/sdram_cfg_check.sv
module sdram_cfg_check #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int IW     = 16
) (
  input  logic [1:0]    col_code,
  input  logic [1:0]    row_code,
  input  logic          bank_code,
  input  logic [IW-1:0] refresh_interval,
  output logic          cfg_ok
);
  import sdram_init_pkg::*;

  logic row_fits, col_fits, bank_fits, ivl_set;

  always_comb begin
    row_fits  = (int'(row_code) + 11) <= ADDR_W;
    col_fits  = (int'(col_code) + 8) <= COL_BITS_MAX;
    bank_fits = (int'(bank_code) + 1) <= BA_W;
    ivl_set   = refresh_interval != '0;
    cfg_ok    = row_fits && col_fits && bank_fits && ivl_set;
  end
endmodule

// File: rtl/sdram_gap_counter.sv
module sdram_gap_counter #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= W'(RST_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R1: a counter that has run down stays down until reloaded
  assert_gap_holds_R1: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [IW-1:0] interval,
  output logic          ref_req
);
  logic [IW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr     <= '0;
      ref_req <= 1'b0;
    end else if (!run) begin
      tmr     <= interval - 1'b1;
      ref_req <= 1'b0;
    end else if (tmr == '0) begin
      tmr     <= interval - 1'b1;
      ref_req <= 1'b1;
    end else begin
      tmr     <= tmr - 1'b1;
      ref_req <= 1'b0;
    end
  end

  assert_req_only_running_R6: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> run);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int PAUSE_US = 200,
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int TW       = 4,
  parameter int IW       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cas_lat,
  input  logic [1:0]        col_code,
  input  logic [1:0]        row_code,
  input  logic              bank_code,
  input  logic [TW-1:0]     t_rp,
  input  logic [TW-1:0]     t_rc,
  input  logic [IW-1:0]     refresh_interval,
  output logic [3:0]        sd_cmd,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              init_done,
  output logic              ref_req,
  output logic              cfg_err
);
  import sdram_init_pkg::*;

  localparam int PAUSE_CYC = (CLK_HZ / 1_000_000) * PAUSE_US;
  localparam int CW0       = $clog2(PAUSE_CYC + 1);
  localparam int CW        = (CW0 > TW) ? CW0 : TW;
  localparam int RW        = $clog2(REFRESH_BURST + 1);

  seq_state_e        state;
  sd_cmd_e           cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BA_W-1:0]   ba_q;
  logic              done_q, err_q;
  logic [RW-1:0]     refs_left;
  logic              cfg_ok, gap_zero, gap_load;
  logic [CW-1:0]     gap_val;
  logic [ADDR_W-1:0] mode_word;

  sdram_cfg_check #(.ADDR_W(ADDR_W), .BA_W(BA_W), .IW(IW)) u_cfg (
    .col_code(col_code), .row_code(row_code), .bank_code(bank_code),
    .refresh_interval(refresh_interval), .cfg_ok(cfg_ok));

  sdram_gap_counter #(.W(CW), .RST_VAL(PAUSE_CYC - 1)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load), .load_val(gap_val), .zero(gap_zero));

  sdram_refresh_timer #(.IW(IW)) u_rtmr (
    .clk(clk), .rst(rst), .run(done_q), .interval(refresh_interval),
    .ref_req(ref_req));

  // Mode word: burst length 1, sequential, CAS latency at bit CAS_LSB
  always_comb begin
    mode_word = '0;
    mode_word[CAS_LSB +: 3] = cas_lat;
  end

  // Gap length chosen by the command about to issue
  always_comb begin
    gap_load = 1'b0;
    gap_val  = '0;
    if (gap_zero) begin
      case (state)
        ST_PAUSE:  begin gap_load = cfg_ok; gap_val = CW'(t_rp); end
        ST_GAP_RP: begin gap_load = 1'b1;   gap_val = CW'(t_rc); end
        ST_GAP_RC: begin
          gap_load = 1'b1;
          gap_val  = (refs_left != '0) ? CW'(t_rc) : CW'(MRD_CYCLES);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_PAUSE;
      cmd_q     <= CMD_NOP;
      addr_q    <= '0;
      ba_q      <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      refs_left <= '0;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      case (state)
        ST_PAUSE: if (gap_zero) begin
          if (!cfg_ok) begin
            state <= ST_FAULT;
            err_q <= 1'b1;
          end else begin
            cmd_q                <= CMD_PRE;
            addr_q[ALL_BANK_BIT] <= 1'b1;
            refs_left            <= RW'(REFRESH_BURST);
            state                <= ST_GAP_RP;
          end
        end
        ST_GAP_RP: if (gap_zero) begin
          cmd_q     <= CMD_REF;
          refs_left <= refs_left - 1'b1;
          state     <= ST_GAP_RC;
        end
        ST_GAP_RC: if (gap_zero) begin
          if (refs_left != '0) begin
            cmd_q     <= CMD_REF;
            refs_left <= refs_left - 1'b1;
          end else begin
            cmd_q  <= CMD_MRS;
            addr_q <= mode_word;
            state  <= ST_GAP_MRD;
          end
        end
        ST_GAP_MRD: if (gap_zero) begin
          done_q <= 1'b1;
          state  <= ST_NORMAL;
        end
        default: ;
      endcase
    end
  end

  assign sd_cmd    = cmd_q;
  assign sd_addr   = addr_q;
  assign sd_ba     = ba_q;
  assign init_done = done_q;
  assign cfg_err   = err_q;

  // Observation registers kept for the assertions below
  logic [CW-1:0] chk_age;
  logic          chk_seen;
  logic [RW:0]   chk_refs;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_age  <= '0;
      chk_seen <= 1'b0;
      chk_refs <= '0;
    end else begin
      if (chk_age != CW'(PAUSE_CYC)) chk_age <= chk_age + 1'b1;
      if (sd_cmd != CMD_NOP) chk_seen <= 1'b1;
      if (sd_cmd == CMD_REF) chk_refs <= chk_refs + 1'b1;
    end
  end

  assert_pause_nop_R1: assert property (@(posedge clk) disable iff (rst)
    (chk_age < CW'(PAUSE_CYC)) |-> sd_cmd == CMD_NOP);
  assert_first_precharge_R2: assert property (@(posedge clk) disable iff (rst)
    (sd_cmd != CMD_NOP && !chk_seen) |-> (sd_cmd == CMD_PRE && sd_addr[ALL_BANK_BIT]));
  assert_refresh_bound_R3: assert property (@(posedge clk) disable iff (rst)
    sd_cmd == CMD_REF |-> chk_refs < (RW+1)'(REFRESH_BURST));
  assert_eight_before_mode_R3: assert property (@(posedge clk) disable iff (rst)
    sd_cmd == CMD_MRS |-> chk_refs == (RW+1)'(REFRESH_BURST));
  assert_mode_word_R4: assert property (@(posedge clk) disable iff (rst)
    sd_cmd == CMD_MRS |-> (sd_addr[3:0] == 4'd0 && sd_addr[CAS_LSB +: 3] == cas_lat));
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  assert_done_after_mrd_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> $past(sd_cmd, 4) == CMD_MRS);
  assert_fault_idle_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!init_done && sd_cmd == CMD_NOP));
endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
  localparam int PAUSE = 20000;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
  // event kinds
  localparam int K_CMD = 0, K_DONE = 1, K_REQ = 2, K_ERR = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [2:0]  cas_lat = 3'd2;
  logic [1:0]  col_code = 2'd1, row_code = 2'd2;
  logic        bank_code = 1'b1;
  logic [3:0]  t_rp = 4'd2, t_rc = 4'd6;
  logic [15:0] refresh_interval = 16'd50;
  logic [3:0]  sd_cmd;
  logic [12:0] sd_addr;
  logic [1:0]  sd_ba;
  logic        init_done, ref_req, cfg_err;

  sdram_init_seq dut (
    .clk(clk), .rst(rst), .cas_lat(cas_lat), .col_code(col_code),
    .row_code(row_code), .bank_code(bank_code), .t_rp(t_rp), .t_rc(t_rc),
    .refresh_interval(refresh_interval), .sd_cmd(sd_cmd), .sd_addr(sd_addr),
    .sd_ba(sd_ba), .init_done(init_done), .ref_req(ref_req), .cfg_err(cfg_err));

  typedef struct {
    int    kind;
    int    cyc;
    int    cmd;
    int    addr;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0, n_fail = 0, cyc = 0, total = 0;
  logic done_prev = 1'b0, err_prev = 1'b0;

  always @(posedge clk) begin
    cyc   <= rst ? 0 : cyc + 1;
    total <= total + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int c, input int cmd, input int addr,
                      input string req);
    exp_t e;
    e.kind = kind; e.cyc = c; e.cmd = cmd; e.addr = addr; e.req = req;
    q.push_back(e);
  endtask

  // Monitor: pops expected items as the design produces them
  task automatic observe(input int kind, input int cmd, input int addr, input int ba);
    exp_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R1", "unexpected event kind", kind, -1);
      return;
    end
    e = q.pop_front();
    chk(e.kind == kind, e.req, "event kind", kind, e.kind);
    chk(e.cyc == cyc, e.req, "event cycle", cyc, e.cyc);
    if (kind == K_CMD) begin
      chk(e.cmd == cmd, e.req, "command", cmd, e.cmd);
      chk(e.addr == addr && ba == 0, e.req, "address", addr, e.addr);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      done_prev <= 1'b0;
      err_prev  <= 1'b0;
    end else begin
      if (sd_cmd != NOP) observe(K_CMD, int'(sd_cmd), int'(sd_addr), int'(sd_ba));
      if (init_done && !done_prev) observe(K_DONE, 0, 0, 0);
      if (ref_req) observe(K_REQ, 0, 0, 0);
      if (cfg_err && !err_prev) observe(K_ERR, 0, 0, 0);
      done_prev <= init_done;
      err_prev  <= cfg_err;
    end
  end

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic run_case(input int cas, input int rp, input int rc, input int ivl,
                          input int ivl2, input int col, input int row, input int bank,
                          input bit bad, input string bad_req);
    int r, m, d, p1, p2, p3, stop;
    @(negedge clk);
    rst = 1'b1;
    cas_lat = 3'(cas); t_rp = 4'(rp); t_rc = 4'(rc);
    refresh_interval = 16'(ivl); col_code = 2'(col); row_code = 2'(row);
    bank_code = 1'(bank);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sd_cmd == NOP, "R1", "reset cmd", int'(sd_cmd), int'(NOP));
    chk(!init_done && !ref_req && !cfg_err, "R1", "reset flags",
        int'({init_done, ref_req, cfg_err}), 0);
    q.delete();
    if (bad) begin
      push(K_ERR, PAUSE, 0, 0, bad_req);
      stop = PAUSE + 300;
      p1 = stop;
    end else begin
      push(K_CMD, PAUSE, int'(PRE), 1 << 10, "R2");
      r = PAUSE + rp + 1;
      for (int i = 0; i < 8; i++) begin
        push(K_CMD, r, int'(REF), 0, "R3");
        r += rc + 1;
      end
      m = r;
      push(K_CMD, m, int'(MRS), cas << 4, "R4");
      d = m + 4;
      push(K_DONE, d, 0, 0, "R5");
      p1 = d + ivl; p2 = p1 + ivl; p3 = p2 + ivl2;
      push(K_REQ, p1, 0, 0, "R6");
      push(K_REQ, p2, 0, 0, "R6");
      push(K_REQ, p3, 0, 0, "R6");
      stop = p3 + 3;
    end
    rst = 1'b0;
    wait_cyc(p1);
    refresh_interval = 16'(ivl2);
    wait_cyc(stop);
    chk(q.size() == 0, bad ? bad_req : "R6", "missing events", q.size(), 0);
    if (bad) begin
      chk(cfg_err && !init_done, bad_req, "halt flags",
          int'({cfg_err, init_done}), 2);
    end else begin
      chk(init_done && !cfg_err, "R5", "done held", int'({init_done, cfg_err}), 2);
    end
  endtask

  initial begin
    run_case(2, 2, 6, 50, 50, 1, 2, 1, 1'b0, "");
    run_case(3, 0, 1, 7, 12, 2, 0, 0, 1'b0, "");
    run_case(2, 2, 6, 0, 0, 1, 2, 1, 1'b1, "R7");
    run_case(2, 2, 6, 40, 40, 1, 3, 1, 1'b1, "R8");
    run_case(2, 2, 6, 40, 40, 3, 0, 1, 1'b1, "R8");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(negedge clk) begin
    if (total >= 190000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", total);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule